// File: doc/BRIEF.md
# Power-On Startup Sequencer

This block takes a small configurable logic device from the moment its supply becomes valid to normal operation. A digital supply-good flag stands in for the analog threshold comparator. Once that flag is high, the block works through a fixed series of phases. It first keeps every device pin in high impedance. It then reads a fixed number of configuration words from a one-time-programmable memory into shadow registers, with the internal logic held in reset. After the load it releases that reset, then enables the weak pull resistors, and at the end raises a startup-complete flag. Delay cells are forced to pass their input straight through until the end of the sequence.

The memory has a simple synchronous read port with one cycle of latency. The block reads one word per clock from consecutive addresses starting at zero. If the supply-good flag falls at any time, whether in mid-sequence or during a normal power-down, the block returns on the next clock to its power-off state and clears the shadow registers. The next rise of the flag starts the whole sequence again.

An optional fast-settling resistor enable is controlled by bit 0 of configuration word 0. It is only ever active together with the weak pulls.

Top module: `power_startup_seq`

## Requirements
- R1: After synchronous reset, and whenever the sequence is idle, the outputs hold these values: io_hiz=1, core_rst=1, dly_bypass=1, pull_en=0, fast_chg_en=0, por_done=0, mem_rd_en=0 and cfg_words=0.
- R2: While supply_ok is low the block stays idle. The sequence starts at the first clock edge that samples supply_ok high.
- R3: The load phase starts on the first clock after that edge. For NUM_WORDS consecutive cycles mem_rd_en is high and mem_addr steps 0, 1, ..., NUM_WORDS-1.
- R4: Shadow word k, which sits at cfg_words bits [k*DATA_W +: DATA_W], receives the memory data for address k one cycle after the read. All words are valid by the time core_rst falls.
- R5: core_rst stays high throughout the load and falls two cycles after the last read cycle. With NUM_WORDS=4 it first reads low in cycle 6, counting the cycle after the starting edge as cycle 1.
- R6: pull_en rises exactly one cycle after core_rst falls, and is low whenever core_rst is high.
- R7: por_done rises exactly one cycle after pull_en. In that same cycle io_hiz and dly_bypass fall.
- R8: fast_chg_en equals pull_en AND bit 0 of shadow word 0.
- R9: When supply_ok is sampled low at any edge, the next cycle shows the R1 idle values, including cfg_words=0. A later rise of supply_ok re-runs the full sequence.
- R10: io_hiz is high during every memory read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above rising threshold |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the request |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| cfg_words | output | NUM_WORDS*DATA_W | Shadow configuration registers |
| io_hiz | output | 1 | Hold all device pins in high impedance |
| core_rst | output | 1 | Reset to internal logic cells |
| dly_bypass | output | 1 | Force delay cells to pass-through |
| pull_en | output | 1 | Enable the weak pull resistors |
| fast_chg_en | output | 1 | Enable the fast-settling resistor |
| por_done | output | 1 | Startup sequence complete |

## Verification
Every control output is decoded from a single registered state. Each output therefore changes one cycle after the edge that moves the state. Counting cycle 1 as the cycle after the edge that first samples supply_ok high, the reads fall in cycles 1 to NUM_WORDS, core_rst falls in cycle NUM_WORDS+2, pull_en rises in cycle NUM_WORDS+3, and por_done rises in cycle NUM_WORDS+4. A supply drop shows up one cycle after the edge that samples it. The bench drives its inputs and samples the outputs on the falling edge. At each falling edge it compares every output with a function of that cycle number, so each result is checked in the exact cycle it is due.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LOAD,
        ST_DRAIN,
        ST_RELEASE,
        ST_PULL,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic io_hiz;
        logic core_rst;
        logic dly_bypass;
        logic pull_en;
        logic por_done;
    } seq_ctrl_t;

    // Control outputs implied by each phase
    function automatic seq_ctrl_t decode_ctrl(input seq_state_t s);
        seq_ctrl_t c;
        c.io_hiz     = (s != ST_DONE);
        c.dly_bypass = (s != ST_DONE);
        c.core_rst   = (s == ST_OFF) || (s == ST_LOAD) || (s == ST_DRAIN);
        c.pull_en    = (s == ST_PULL) || (s == ST_DONE);
        c.por_done   = (s == ST_DONE);
        return c;
    endfunction

endpackage

// File: rtl/startup_fsm.sv
module startup_fsm
    import startup_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    output seq_state_t        state,
    output logic [ADDR_W-1:0] rd_idx,
    output logic              rd_en
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            state  <= ST_OFF;
            rd_idx <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    state  <= ST_LOAD;
                    rd_idx <= '0;
                end
                ST_LOAD: begin
                    if (rd_idx == LAST_IDX) begin
                        state <= ST_DRAIN;
                    end else begin
                        rd_idx <= rd_idx + 1'b1;
                    end
                end
                ST_DRAIN:   state <= ST_RELEASE;
                ST_RELEASE: state <= ST_PULL;
                ST_PULL:    state <= ST_DONE;
                ST_DONE:    state <= ST_DONE;
                default:    state <= ST_OFF;
            endcase
        end
    end

    assign rd_en = (state == ST_LOAD);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_idx,
    input  logic [DATA_W-1:0]           rdata,
    output logic [NUM_WORDS*DATA_W-1:0] cfg_words
);

    logic              resp_vld;
    logic [ADDR_W-1:0] resp_idx;

    // Track which word the memory returns in the next cycle
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            resp_vld <= 1'b0;
            resp_idx <= '0;
        end else begin
            resp_vld <= rd_en;
            resp_idx <= rd_idx;
        end
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_shadow
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                word_q <= '0;
            end else if (resp_vld && (resp_idx == ADDR_W'(k))) begin
                word_q <= rdata;
            end
        end
        assign cfg_words[k*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/power_startup_seq.sv
module power_startup_seq
    import startup_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        supply_ok,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [NUM_WORDS*DATA_W-1:0] cfg_words,
    output logic                        io_hiz,
    output logic                        core_rst,
    output logic                        dly_bypass,
    output logic                        pull_en,
    output logic                        fast_chg_en,
    output logic                        por_done
);

    seq_state_t        state;
    seq_ctrl_t         ctrl;
    logic [ADDR_W-1:0] rd_idx;
    logic              rd_en;

    startup_fsm #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .state     (state),
        .rd_idx    (rd_idx),
        .rd_en     (rd_en)
    );

    cfg_loader #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_loader (
        .clk       (clk),
        .rst       (rst),
        .clear     (!supply_ok),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rdata     (mem_rdata),
        .cfg_words (cfg_words)
    );

    assign ctrl        = decode_ctrl(state);
    assign mem_rd_en   = rd_en;
    assign mem_addr    = rd_idx;
    assign io_hiz      = ctrl.io_hiz;
    assign core_rst    = ctrl.core_rst;
    assign dly_bypass  = ctrl.dly_bypass;
    assign pull_en     = ctrl.pull_en;
    assign por_done    = ctrl.por_done;
    assign fast_chg_en = ctrl.pull_en & cfg_words[0];

endmodule

// File: rtl/power_startup_seq_chk.sv
module power_startup_seq_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              io_hiz,
    input logic              core_rst,
    input logic              dly_bypass,
    input logic              pull_en,
    input logic              fast_chg_en,
    input logic              por_done
);

    assert_drop_off_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (io_hiz && core_rst && dly_bypass && !pull_en && !por_done && !mem_rd_en));

    assert_load_hiz_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (io_hiz && core_rst && dly_bypass));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_rst_release_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (!$past(mem_rd_en) && !pull_en));

    assert_pull_order_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_en) |-> (!core_rst && !$past(core_rst) && !por_done));

    assert_done_order_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(por_done) |-> ($past(pull_en) && !io_hiz && !dly_bypass));

    assert_fast_chg_R8: assert property (@(posedge clk) disable iff (rst)
        fast_chg_en |-> pull_en);

endmodule

bind power_startup_seq power_startup_seq_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok   (supply_ok),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .io_hiz      (io_hiz),
    .core_rst    (core_rst),
    .dly_bypass  (dly_bypass),
    .pull_en     (pull_en),
    .fast_chg_en (fast_chg_en),
    .por_done    (por_done)
);

// File: tb/power_startup_seq_bench.sv
module power_startup_seq_bench;

    localparam int N      = 4;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int DEPTH  = 1 << AW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            supply_ok = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;
    logic            mem_rd_en;
    logic [AW-1:0]   mem_addr;
    logic [N*DW-1:0] cfg_words;
    logic            io_hiz, core_rst, dly_bypass, pull_en, fast_chg_en, por_done;

    logic [DW-1:0]   mem [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    power_startup_seq #(.NUM_WORDS(N), .ADDR_W(AW), .DATA_W(DW)) u_power_startup_seq (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .mem_rdata   (mem_rdata),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .cfg_words   (cfg_words),
        .io_hiz      (io_hiz),
        .core_rst    (core_rst),
        .dly_bypass  (dly_bypass),
        .pull_en     (pull_en),
        .fast_chg_en (fast_chg_en),
        .por_done    (por_done)
    );

    // Synchronous memory model, one cycle read latency
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N*DW-1:0] exp_cfg();
        logic [N*DW-1:0] v;
        for (int k = 0; k < N; k++) v[k*DW +: DW] = mem[k];
        return v;
    endfunction

    // Expected controls in cycle c after the starting edge (c=0: idle)
    task automatic check_cycle(input int c);
        logic e_load, e_rst, e_pull, e_done;
        e_load = (c >= 1) && (c <= N);
        e_rst  = (c <= N + 1);
        e_pull = (c >= N + 3);
        e_done = (c >= N + 4);
        chk("R3",  "mem_rd_en", mem_rd_en, e_load);
        if (e_load) chk("R3", "mem_addr", mem_addr, c - 1);
        chk("R5",  "core_rst", core_rst, e_rst);
        chk("R6",  "pull_en", pull_en, e_pull);
        chk("R7",  "por_done", por_done, e_done);
        chk("R7",  "dly_bypass", dly_bypass, !e_done);
        chk("R10", "io_hiz", io_hiz, !e_done);
        chk("R8",  "fast_chg_en", fast_chg_en, e_pull && mem[0][0]);
        if (c == N + 2) chk("R4", "cfg_words", cfg_words, exp_cfg());
    endtask

    task automatic check_idle(input string req);
        chk(req, "io_hiz", io_hiz, 1'b1);
        chk(req, "core_rst", core_rst, 1'b1);
        chk(req, "dly_bypass", dly_bypass, 1'b1);
        chk(req, "pull_en", pull_en, 1'b0);
        chk(req, "fast_chg_en", fast_chg_en, 1'b0);
        chk(req, "por_done", por_done, 1'b0);
        chk(req, "mem_rd_en", mem_rd_en, 1'b0);
        chk(req, "cfg_words", cfg_words, '0);
    endtask

    // drop_at=0: full run, then a normal power-down
    task automatic run_seq(input int drop_at);
        @(negedge clk) supply_ok = 1'b1;
        for (int c = 1; c <= N + 6; c++) begin
            @(negedge clk);
            check_cycle(c);
            if (c == drop_at) begin
                supply_ok = 1'b0;
                @(negedge clk);
                check_idle("R9");
                return;
            end
        end
        chk("R4", "cfg_words_hold", cfg_words, exp_cfg());
        supply_ok = 1'b0;
        @(negedge clk);
        check_idle("R9");
    endtask

    task automatic fill_mem();
        for (int a = 0; a < DEPTH; a++) mem[a] = DW'($urandom);
    endtask

    initial begin
        void'($urandom(32'd5150));
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1");
        // Supply stays low: nothing starts (R2)
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2", "mem_rd_en_idle", mem_rd_en, 1'b0);
            chk("R2", "core_rst_idle", core_rst, 1'b1);
        end
        // Directed: quick-charge bit set, then clear
        mem[0][0] = 1'b1;
        run_seq(0);
        mem[0][0] = 1'b0;
        run_seq(0);
        // Directed drops: first load cycle, at release, after done
        run_seq(1);
        run_seq(N + 2);
        run_seq(N + 5);
        // Random contents and drop points, each followed by a full restart
        for (int r = 0; r < 10; r++) begin
            fill_mem();
            run_seq($urandom_range(0, N + 6));
            run_seq(0);
        end
        repeat (2) @(negedge clk);
        check_idle("R1");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule